// File: doc/BRIEF.md
# Posted Write Buffer Controller

This block sits between an upstream bus that issues memory writes and a downstream bus that carries them on. An upstream write begins with an address phase and continues with one or more data phases. The block answers each data phase at once and stores the word in a 16-word buffer, so the upstream master does not wait for the downstream side. Words are then sent downstream as write requests. Each request carries a start address, a burst flag, and first and last markers.

At most two upstream writes can be held at the same time, in any mix of single words and bursts. An address phase that cannot be taken is refused with retry. A burst that reaches a full buffer is cut off with a disconnect on the word that fills it. A downstream request starts when its write has closed upstream, or earlier once six words of an open burst are buffered. Upstream data keeps flowing while the request drains. If the drain catches up with the incoming data, the downstream request ends early. A new request then continues from the next address once enough data is buffered again. Writes leave in the order they arrived.

Top module: `pwb_post_buffer`

## Requirements
- R1: After reset, `dn_valid`, `up_ready`, `up_stop` and `up_retry` are all 0.
- R2: An address phase (`up_req`=1) is taken, with `up_retry`=0, only when fewer than two writes are held, the buffer is not full and no write is still open. With two writes held it gets `up_retry`=1.
- R3: An address phase while all 16 words are occupied gets `up_retry`=1, even with only one write held.
- R4: While a write is open, `up_ready`=1 and one data word is taken on each clock edge where `up_valid`=1. A word taken with `up_last`=1 closes the write, and `up_ready` then returns to 0.
- R5: No downstream beat of a write starts (`dn_first`) until that write is closed, or until at least six of its words are buffered.
- R6: Downstream beats of a write carry its start address plus 4 per word, and its data words in arrival order.
- R7: A word taken while 15 words are buffered, and not marked last, is answered with `up_stop`=1. That word ends the write, and `up_ready` is 0 from the next cycle.
- R8: If a downstream beat drains the last buffered word of a write that is still open, that beat has `dn_last`=1. The next request for that write starts with `dn_first`=1 at the following address, once the R5 condition holds again.
- R9: `dn_burst` is 0 on a request that is a closed write with exactly one word left, and 1 on every other request.
- R10: Writes go downstream in the order their address phases were taken.
- R11: A refused address phase leaves the buffered words, their addresses and their order unchanged.
- R12: Upstream words are taken in the same cycles that downstream beats drain, so a long burst starts draining before its last word arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_req | input | 1 | Upstream address phase |
| up_addr | input | AW | Byte start address of the upstream write |
| up_retry | output | 1 | Address phase refused |
| up_valid | input | 1 | Upstream data phase present |
| up_data | input | DW | Upstream data word |
| up_last | input | 1 | This data phase ends the upstream write |
| up_ready | output | 1 | Data word is taken on this edge |
| up_stop | output | 1 | Disconnect: this word is the final one taken for the write |
| dn_valid | output | 1 | Downstream beat present |
| dn_ready | input | 1 | Downstream side takes the beat |
| dn_addr | output | AW | Byte address of the beat |
| dn_data | output | DW | Data word of the beat |
| dn_burst | output | 1 | The current request is a burst |
| dn_first | output | 1 | First beat of a request |
| dn_last | output | 1 | Final beat of a request |

## Verification
The hardest state to reach is a write that is still open upstream with nothing left to drain, because the drain must outrun the incoming data. The bench gets there by sending exactly six words and then pausing the upstream side while the downstream side stays ready. The drain then empties the write and ends early. The bench next adds a few words below the threshold, which must not restart the drain, and then closes the write so the resumed request can be checked for address and flags. The full-buffer cases are reached by holding `dn_ready` low while the upstream side posts.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

   // Downstream sequencing: between requests, or inside one
   typedef enum logic {
      DR_IDLE  = 1'b0,
      DR_BURST = 1'b1
   } drain_st_e;

   // Number of posted writes tracked at once
   localparam int unsigned PWB_SLOTS = 2;

endpackage

// File: rtl/pwb_word_store.sv
module pwb_word_store #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] count,
   output logic          full
);

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;

   generate
      if (DEPTH == (1 << PW)) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (wr_en) wp <= wp_nx;
         if (rd_en) rp <= rp_nx;
         case ({wr_en, rd_en})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign rd_data = mem[rp];
   assign full    = (count == CW'(DEPTH));

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !full);
   p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (count != '0));

endmodule

// File: rtl/pwb_txn_queue.sv
module pwb_txn_queue #(
   parameter int unsigned AW    = 32,
   parameter int unsigned CW    = 5,
   parameter int unsigned BYTES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic          wr,
   input  logic          wr_close,
   input  logic          rd,
   output logic [1:0]    nrec,
   output logic          open,
   output logic [AW-1:0] head_addr,
   output logic [CW-1:0] head_nbuf,
   output logic          head_done
);

   import pwb_pkg::*;

   logic                 hp;
   logic [1:0]           nrec_q;
   logic                 tail, slot_new, retire;
   logic [PWB_SLOTS-1:0][AW-1:0] addr_v;
   logic [PWB_SLOTS-1:0][CW-1:0] nbuf_v;
   logic [PWB_SLOTS-1:0]         done_v;

   assign tail     = hp ^ nrec_q[1];
   assign slot_new = hp ^ nrec_q[0];
   assign retire   = rd && done_v[hp] && (nbuf_v[hp] == CW'(1));

   generate
      for (genvar s = 0; s < PWB_SLOTS; s++) begin : g_slot
         logic          take, inc, dec;
         logic [AW-1:0] a_q;
         logic [CW-1:0] n_q;
         logic          d_q;

         assign take = push && (slot_new == 1'(s));
         assign inc  = wr && (tail == 1'(s));
         assign dec  = rd && (hp == 1'(s));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               a_q <= '0;
               n_q <= '0;
               d_q <= 1'b0;
            end else if (take) begin
               a_q <= push_addr;
               n_q <= '0;
               d_q <= 1'b0;
            end else begin
               if (dec) a_q <= a_q + AW'(BYTES);
               case ({inc, dec})
                  2'b10:   n_q <= n_q + 1'b1;
                  2'b01:   n_q <= n_q - 1'b1;
                  default: n_q <= n_q;
               endcase
               if (inc && wr_close) d_q <= 1'b1;
            end
         end

         assign addr_v[s] = a_q;
         assign nbuf_v[s] = n_q;
         assign done_v[s] = d_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hp     <= 1'b0;
         nrec_q <= '0;
      end else begin
         nrec_q <= nrec_q + {1'b0, push} - {1'b0, retire};
         if (retire) hp <= ~hp;
      end
   end

   assign nrec      = nrec_q;
   assign open      = (nrec_q != 2'd0) && !done_v[tail];
   assign head_addr = addr_v[hp];
   assign head_nbuf = nbuf_v[hp];
   assign head_done = done_v[hp];

   p_two_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
      nrec_q <= 2'd2);
   p_push_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (nrec_q < 2'd2) && !open);
   p_wr_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> open);
   p_drain_head_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd |-> (nrec_q != 2'd0) && (nbuf_v[hp] != '0));

endmodule

// File: rtl/pwb_drain_ctl.sv
module pwb_drain_ctl #(
   parameter int unsigned CW          = 5,
   parameter int unsigned START_WORDS = 6,
   parameter bit          EARLY_START = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          have_rec,
   input  logic [CW-1:0] head_nbuf,
   input  logic          head_done,
   input  logic          dn_ready,
   output logic          dn_valid,
   output logic          dn_first,
   output logic          dn_last,
   output logic          dn_burst,
   output logic          beat
);

   import pwb_pkg::*;

   drain_st_e st;
   logic      has_word, go, lone;

   assign has_word = have_rec && (head_nbuf != '0);
   assign lone     = head_done && (head_nbuf == CW'(1));

   generate
      if (EARLY_START) begin : g_early
         assign go = head_done || (head_nbuf >= CW'(START_WORDS));
      end else begin : g_closed
         assign go = head_done;
      end
   endgenerate

   assign dn_valid = has_word && ((st == DR_BURST) || go);
   assign dn_first = dn_valid && (st == DR_IDLE);
   assign dn_last  = dn_valid && (head_nbuf == CW'(1));
   assign dn_burst = dn_valid && ((st == DR_BURST) || !lone);
   assign beat     = dn_valid && dn_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    st <= DR_IDLE;
      else if (beat) st <= dn_last ? DR_IDLE : DR_BURST;
   end

   p_start_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dn_first |-> head_done || (head_nbuf >= CW'(START_WORDS)));
   p_burst_continues_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !dn_last) |=> dn_valid && !dn_first);

endmodule

// File: rtl/pwb_post_buffer.sv
module pwb_post_buffer #(
   parameter int unsigned AW          = 32,
   parameter int unsigned DW          = 32,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned START_WORDS = 6,
   parameter bit          EARLY_START = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          up_req,
   input  logic [AW-1:0] up_addr,
   output logic          up_retry,
   input  logic          up_valid,
   input  logic [DW-1:0] up_data,
   input  logic          up_last,
   output logic          up_ready,
   output logic          up_stop,
   output logic          dn_valid,
   input  logic          dn_ready,
   output logic [AW-1:0] dn_addr,
   output logic [DW-1:0] dn_data,
   output logic          dn_burst,
   output logic          dn_first,
   output logic          dn_last
);

   localparam int unsigned BYTES = DW / 8;
   localparam int unsigned CW    = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || START_WORDS < 1 || START_WORDS > DEPTH || (DW % 8) != 0) begin : g_bad_cfg
         $error("pwb_post_buffer: unsupported parameter set");
      end
   endgenerate

   logic [CW-1:0] count, head_nbuf;
   logic          full, open, head_done, acc, fill, push, beat;
   logic [1:0]    nrec;

   assign up_retry = up_req && ((nrec == 2'd2) || full || open);
   assign push     = up_req && !up_retry;
   assign up_ready = open && !full;
   assign acc      = up_valid && up_ready;
   assign fill     = (count == CW'(DEPTH - 1));
   assign up_stop  = acc && !up_last && fill;

   pwb_word_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (acc),
      .wr_data (up_data),
      .rd_en   (beat),
      .rd_data (dn_data),
      .count   (count),
      .full    (full)
   );

   pwb_txn_queue #(.AW(AW), .CW(CW), .BYTES(BYTES)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_addr (up_addr),
      .wr        (acc),
      .wr_close  (up_last || fill),
      .rd        (beat),
      .nrec      (nrec),
      .open      (open),
      .head_addr (dn_addr),
      .head_nbuf (head_nbuf),
      .head_done (head_done)
   );

   pwb_drain_ctl #(.CW(CW), .START_WORDS(START_WORDS), .EARLY_START(EARLY_START)) u_drain (
      .clk       (clk),
      .rst_n     (rst_n),
      .have_rec  (nrec != 2'd0),
      .head_nbuf (head_nbuf),
      .head_done (head_done),
      .dn_ready  (dn_ready),
      .dn_valid  (dn_valid),
      .dn_first  (dn_first),
      .dn_last   (dn_last),
      .dn_burst  (dn_burst),
      .beat      (beat)
   );

   p_retry_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req && full) |-> up_retry);
   p_retry_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req && nrec == 2'd2) |-> up_retry);
   p_disconnect_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      up_stop |=> !up_ready);

endmodule

// File: tb/pwb_post_buffer_test.sv
`timescale 1ns/100ps
module pwb_post_buffer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        up_req = 1'b0, up_valid = 1'b0, up_last = 1'b0, dn_ready = 1'b0;
   logic [31:0] up_addr = '0, up_data = '0;
   logic        up_retry, up_ready, up_stop, dn_valid, dn_burst, dn_first, dn_last;
   logic [31:0] dn_addr, dn_data;

   int n_checks = 0, n_err = 0;
   bit finished = 1'b0;

   logic [31:0] lg_addr [256];
   logic [31:0] lg_data [256];
   logic        lg_first [256];
   logic        lg_last [256];
   logic        lg_burst [256];
   int          lg_n = 0;

   always #2.5 clk = ~clk;

   pwb_post_buffer uut (
      .clk(clk), .rst_n(rst_n),
      .up_req(up_req), .up_addr(up_addr), .up_retry(up_retry),
      .up_valid(up_valid), .up_data(up_data), .up_last(up_last),
      .up_ready(up_ready), .up_stop(up_stop),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_data(dn_data),
      .dn_burst(dn_burst), .dn_first(dn_first), .dn_last(dn_last)
   );

   // downstream monitor: samples 1 ns before each rising edge
   always begin
      @(negedge clk);
      #1.5;
      if (rst_n && dn_valid && dn_ready) begin
         lg_addr[lg_n & 255]  = dn_addr;
         lg_data[lg_n & 255]  = dn_data;
         lg_first[lg_n & 255] = dn_first;
         lg_last[lg_n & 255]  = dn_last;
         lg_burst[lg_n & 255] = dn_burst;
         lg_n = lg_n + 1;
      end
   end

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_beat(input string req, input int idx, input logic [31:0] a, input logic [31:0] d,
                           input logic f, input logic l, input logic b);
      chk(req, $sformatf("beat %0d addr", idx), 64'(lg_addr[idx & 255]), 64'(a));
      chk(req, $sformatf("beat %0d data", idx), 64'(lg_data[idx & 255]), 64'(d));
      chk(req, $sformatf("beat %0d first/last/burst", idx),
          64'({lg_first[idx & 255], lg_last[idx & 255], lg_burst[idx & 255]}), 64'({f, l, b}));
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic addr_phase(input logic [31:0] a, output bit retried);
      @(negedge clk);
      up_req = 1'b1;
      up_addr = a;
      #1;
      retried = up_retry;
      @(posedge clk);
      #1;
      up_req = 1'b0;
   endtask

   task automatic send_word(input logic [31:0] d, input logic last, output bit rdy, output bit stp);
      @(negedge clk);
      up_valid = 1'b1;
      up_data = d;
      up_last = last;
      #1;
      rdy = up_ready;
      stp = up_stop;
      @(posedge clk);
      #1;
      up_valid = 1'b0;
      up_last = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      #1;
      chk("R1", "outputs after reset", 64'({dn_valid, up_ready, up_stop, up_retry}), 64'(0));
   endtask

   task automatic t_single;
      bit r, s;
      int base;
      base = lg_n;
      dn_ready = 1'b1;
      addr_phase(32'h1000, r);
      chk("R2", "single addr retry", 64'(r), 64'(0));
      send_word(32'hA000_0001, 1'b1, r, s);
      chk("R4", "single word ready", 64'(r), 64'(1));
      #1;
      chk("R4", "ready after last", 64'(up_ready), 64'(0));
      idle(5);
      chk("R9", "single beat count", 64'(lg_n - base), 64'(1));
      chk_beat("R9", base, 32'h1000, 32'hA000_0001, 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_short_burst;
      bit r, s;
      int base;
      base = lg_n;
      dn_ready = 1'b1;
      addr_phase(32'h1100, r);
      for (int i = 0; i < 3; i++) send_word(32'hB000_0000 + 32'(i), 1'b0, r, s);
      idle(6);
      chk("R5", "no drain before close", 64'(lg_n - base), 64'(0));
      send_word(32'hB000_0003, 1'b1, r, s);
      idle(8);
      chk("R6", "short burst beats", 64'(lg_n - base), 64'(4));
      for (int i = 0; i < 4; i++)
         chk_beat("R6", base + i, 32'h1100 + 32'(4 * i), 32'hB000_0000 + 32'(i),
                  (i == 0), (i == 3), 1'b1);
   endtask

   task automatic t_early;
      bit r, s;
      int base;
      base = lg_n;
      dn_ready = 1'b1;
      addr_phase(32'h2200, r);
      for (int i = 0; i < 8; i++) send_word(32'hC000_0000 + 32'(i), 1'b0, r, s);
      chk("R12", "drain before last word", 64'(lg_n - base > 0), 64'(1));
      send_word(32'hC000_0008, 1'b0, r, s);
      send_word(32'hC000_0009, 1'b1, r, s);
      idle(12);
      chk("R12", "early burst beats", 64'(lg_n - base), 64'(10));
      for (int i = 0; i < 10; i++)
         chk_beat("R5", base + i, 32'h2200 + 32'(4 * i), 32'hC000_0000 + 32'(i),
                  (i == 0), (i == 9), 1'b1);
   endtask

   task automatic t_terminate;
      bit r, s;
      int base, mid;
      base = lg_n;
      dn_ready = 1'b1;
      addr_phase(32'h3300, r);
      for (int i = 0; i < 6; i++) send_word(32'hD000_0000 + 32'(i), 1'b0, r, s);
      idle(12);
      chk("R8", "beats before pause ends", 64'(lg_n - base), 64'(6));
      chk_beat("R8", base + 5, 32'h3314, 32'hD000_0005, 1'b0, 1'b1, 1'b1);
      mid = lg_n;
      for (int i = 6; i < 9; i++) send_word(32'hD000_0000 + 32'(i), 1'b0, r, s);
      idle(8);
      chk("R5", "no restart below threshold", 64'(lg_n - mid), 64'(0));
      send_word(32'hD000_0009, 1'b1, r, s);
      idle(8);
      chk("R8", "resumed beats", 64'(lg_n - mid), 64'(4));
      for (int i = 0; i < 4; i++)
         chk_beat("R8", mid + i, 32'h3318 + 32'(4 * i), 32'hD000_0006 + 32'(i),
                  (i == 0), (i == 3), 1'b1);
   endtask

   task automatic t_two_posted;
      bit r, s;
      int base;
      base = lg_n;
      dn_ready = 1'b0;
      addr_phase(32'h4000, r);
      send_word(32'hE000_0000, 1'b1, r, s);
      addr_phase(32'h5000, r);
      chk("R2", "second write taken", 64'(r), 64'(0));
      send_word(32'hE000_0001, 1'b0, r, s);
      send_word(32'hE000_0002, 1'b1, r, s);
      addr_phase(32'h6000, r);
      chk("R2", "third write retried", 64'(r), 64'(1));
      #1;
      chk("R11", "no open write after retry", 64'(up_ready), 64'(0));
      idle(3);
      chk("R11", "nothing drained while stalled", 64'(lg_n - base), 64'(0));
      dn_ready = 1'b1;
      idle(8);
      chk("R10", "posted beats", 64'(lg_n - base), 64'(3));
      chk_beat("R10", base,     32'h4000, 32'hE000_0000, 1'b1, 1'b1, 1'b0);
      chk_beat("R10", base + 1, 32'h5000, 32'hE000_0001, 1'b1, 1'b0, 1'b1);
      chk_beat("R11", base + 2, 32'h5004, 32'hE000_0002, 1'b0, 1'b1, 1'b1);
   endtask

   task automatic t_fill;
      bit r, s;
      int base, taken, stop_at;
      base = lg_n;
      taken = 0;
      stop_at = -1;
      dn_ready = 1'b0;
      addr_phase(32'h7000, r);
      for (int i = 0; i < 20; i++) begin
         if (stop_at < 0) begin
            send_word(32'hF000_0000 + 32'(i), 1'b0, r, s);
            if (r) taken++;
            if (s) stop_at = i;
         end
      end
      chk("R7", "words taken before disconnect", 64'(taken), 64'(16));
      chk("R7", "disconnect word index", 64'(stop_at), 64'(15));
      idle(1);
      #1;
      chk("R7", "ready after disconnect", 64'(up_ready), 64'(0));
      addr_phase(32'h8000, r);
      chk("R3", "retry when buffer full", 64'(r), 64'(1));
      dn_ready = 1'b1;
      idle(22);
      chk("R11", "full buffer beats", 64'(lg_n - base), 64'(16));
      for (int i = 0; i < 16; i++)
         chk_beat("R6", base + i, 32'h7000 + 32'(4 * i), 32'hF000_0000 + 32'(i),
                  (i == 0), (i == 15), 1'b1);
      addr_phase(32'h8000, r);
      chk("R3", "taken after drain", 64'(r), 64'(0));
      send_word(32'h1234_5678, 1'b1, r, s);
      idle(5);
      chk("R10", "beat after refill", 64'(lg_n - base), 64'(17));
      chk_beat("R9", base + 16, 32'h8000, 32'h1234_5678, 1'b1, 1'b1, 1'b0);
   endtask

   initial begin
      #(5 * 100000);
      if (!finished) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single();
      t_short_burst();
      t_early();
      t_terminate();
      t_two_posted();
      t_fill();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule